// File: doc/BRIEF.md
# Instruction Boundary Predecoder with Mark Store

This block sits between the instruction cache and the decoders of a variable-length instruction pipeline. Each accepted fetch brings in a chunk of `CHUNK_BYTES` instruction bytes, named by a cache line and a chunk slot within that line. The block returns the same bytes together with one start-of-instruction mark bit per byte. A mark store keeps the computed marks for every chunk slot, along with the scanner state left at the chunk's end. A chunk whose marks are already stored is returned after one cycle with those marks. A chunk without stored marks goes through a slower scan path that takes `PRE_STAGES` extra cycles. The result of that scan is written back to the store, so later fetches of the chunk take the fast path.

The scanner uses a reduced length rule set: prefix bytes, a one-byte opcode or an escape byte followed by a second opcode byte, an optional ModRM byte with no displacement, and an immediate of 0, 1 or 4 bytes. An instruction that runs past the end of a chunk leaves a scanner state behind. That state is applied to the first bytes of the next chunk, so no false start is flagged inside the instruction. Refilling a cache line invalidates every stored chunk of that line. Every chunk leaves the block toward full decode, whichever path produced its marks.

Top module: `boundary_predecode`

## Requirements
- R1: Each returned chunk carries the fetched bytes unchanged. Byte k sits at bits 8k+7:8k, and mark bit k belongs to byte k. A set mark means that byte starts an instruction.
- R2: Prefix bytes are 0x66, 0xF0, 0xF2 and 0xF3. Any number of them may precede an opcode. Only the first prefix is marked.
- R2 (continued): Byte 0x0F is followed by a second opcode byte and then a ModRM byte.
- R2 (continued): Opcodes 0x00–0x3F take a ModRM byte when bits 2:0 are below 4, an 8-bit immediate when bits 2:0 equal 4, and a 32-bit immediate when bits 2:0 equal 5.
- R2 (continued): Opcodes 0x70–0x7F, 0xB0–0xB7 and 0xEB take an 8-bit immediate. Opcodes 0xB8–0xBF, 0xE8 and 0xE9 take a 32-bit immediate.
- R2 (continued): Opcodes 0x80, 0x82, 0x83 and 0xC6 take ModRM plus an 8-bit immediate. Opcodes 0x81 and 0xC7 take ModRM plus a 32-bit immediate. The other opcodes 0x84–0x8F take ModRM only.
- R2 (continued): Every other byte in opcode position is a one-byte instruction.
- R3: The scanner state at the end of a chunk is carried into the next fetched chunk. Byte 0 is marked only if that carried state is at an instruction start. No byte inside a spanning instruction is marked.
- R4: A fetch whose chunk slot holds valid marks returns the stored marks one cycle after acceptance. `fetch_ready_o` stays high, and the carried state is loaded from the stored end state.
- R5: A fetch without valid marks returns its scan result 1+`PRE_STAGES` cycles after acceptance. `fetch_ready_o` is low until the result appears. The marks and end state are then written to the slot, and the next fetch of that slot hits.
- R6: A refill of a line clears the stored marks of all chunks of that line and leaves other lines untouched. A refill in the same cycle as a fetch of that line makes the fetch miss.
- R7: A refill of the line being scanned, arriving while the scan is pending, blocks the write-back. The next fetch of that slot misses again.
- R8: A fetch with `fetch_restart_i` set starts its scan at an instruction start, whatever the carried state. Without it, a miss scans from the carried state, including a state loaded from the store by a hit.
- R9: After reset, `out_valid_o` is low, `fetch_ready_o` is high, no slot holds valid marks, and the carried state is an instruction start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid_i | input | 1 | Fetch request present |
| fetch_ready_o | output | 1 | Block can accept a fetch |
| fetch_line_i | input | $clog2(LINES) | Cache line of the fetched chunk |
| fetch_chunk_i | input | $clog2(LINE_CHUNKS) | Chunk slot within the line |
| fetch_restart_i | input | 1 | Chunk begins at an instruction start |
| fetch_bytes_i | input | 8*CHUNK_BYTES | Instruction bytes, byte 0 in the low bits |
| refill_i | input | 1 | A cache line is being refilled |
| refill_line_i | input | $clog2(LINES) | Line being refilled |
| out_valid_o | output | 1 | Marked chunk present this cycle |
| out_bytes_o | output | 8*CHUNK_BYTES | Bytes passed to full decode |
| out_marks_o | output | CHUNK_BYTES | Start-of-instruction mark per byte |

## Verification
The bench uses the default parameters: 8-byte chunks, 8 lines of 4 chunk slots, and 3 scan stages. With these values a hit returns after 1 cycle and a miss after 4, so the two paths are told apart by latency alone. Four slots per line let an instruction cross chunk boundaries both within a line and into the next line. Eight lines leave room to refill one line and confirm that a neighbouring line still hits. They also allow a pending scan to be invalidated without disturbing earlier results.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

    // Where the scanner stands before it consumes the next byte.
    typedef enum logic [2:0] {
        PH_START = 3'd0,   // next byte opens a new instruction
        PH_OPC   = 3'd1,   // prefix seen, opcode still expected
        PH_OPC2  = 3'd2,   // escape seen, second opcode byte expected
        PH_MODRM = 3'd3,   // ModRM byte expected, imm_left follows it
        PH_IMM   = 3'd4    // imm_left immediate bytes remain
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        logic [2:0] imm_left;
    } carry_t;

    localparam carry_t CARRY_START = '{phase: PH_START, imm_left: 3'd0};

    // State after a byte in opcode position.
    function automatic carry_t classify(input logic [7:0] b);
        carry_t n;
        n = CARRY_START;
        if (b == 8'h66 || b == 8'hF0 || b == 8'hF2 || b == 8'hF3) begin
            n.phase = PH_OPC;
        end else if (b == 8'h0F) begin
            n.phase = PH_OPC2;
        end else if (b[7:6] == 2'b00 && b[2:0] < 3'd4) begin
            n.phase = PH_MODRM;
        end else if (b[7:6] == 2'b00 && b[2:0] == 3'd4) begin
            n.phase = PH_IMM; n.imm_left = 3'd1;
        end else if (b[7:6] == 2'b00 && b[2:0] == 3'd5) begin
            n.phase = PH_IMM; n.imm_left = 3'd4;
        end else if (b[7:4] == 4'h7 || b[7:3] == 5'b10110 || b == 8'hEB) begin
            n.phase = PH_IMM; n.imm_left = 3'd1;
        end else if (b[7:3] == 5'b10111 || b == 8'hE8 || b == 8'hE9) begin
            n.phase = PH_IMM; n.imm_left = 3'd4;
        end else if (b == 8'h81 || b == 8'hC7) begin
            n.phase = PH_MODRM; n.imm_left = 3'd4;
        end else if (b == 8'h80 || b == 8'h82 || b == 8'h83 || b == 8'hC6) begin
            n.phase = PH_MODRM; n.imm_left = 3'd1;
        end else if (b[7:4] == 4'h8) begin
            n.phase = PH_MODRM;
        end
        return n;
    endfunction

    // One byte of scanning.
    function automatic carry_t step(input carry_t st, input logic [7:0] b);
        carry_t n;
        n = CARRY_START;
        case (st.phase)
            PH_START, PH_OPC: n = classify(b);
            PH_OPC2:          n.phase = PH_MODRM;
            PH_MODRM: begin
                if (st.imm_left != 3'd0) begin
                    n.phase    = PH_IMM;
                    n.imm_left = st.imm_left;
                end
            end
            PH_IMM: begin
                if (st.imm_left > 3'd1) begin
                    n.phase    = PH_IMM;
                    n.imm_left = st.imm_left - 3'd1;
                end
            end
            default: n = CARRY_START;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bpd_scanner.sv
module bpd_scanner
    import bpd_pkg::*;
#(
    parameter int CHUNK_BYTES = 8
) (
    input  carry_t                     carry_i,
    input  logic [8*CHUNK_BYTES-1:0]   bytes_i,
    output logic [CHUNK_BYTES-1:0]     marks_o,
    output carry_t                     carry_o
);

    // Byte-serial walk across the chunk; the state left by byte k
    // decides whether byte k+1 opens an instruction.
    always_comb begin
        carry_t c;
        c = carry_i;
        for (int k = 0; k < CHUNK_BYTES; k++) begin
            marks_o[k] = (c.phase == PH_START);
            c = step(c, bytes_i[8*k +: 8]);
        end
        carry_o = c;
    end

endmodule

// File: rtl/bpd_mark_store.sv
module bpd_mark_store
    import bpd_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int LINE_CHUNKS = 4,
    parameter int CHUNK_BYTES = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(LINES)-1:0]       rd_line_i,
    input  logic [$clog2(LINE_CHUNKS)-1:0] rd_chunk_i,
    output logic                           rd_valid_o,
    output logic [CHUNK_BYTES-1:0]         rd_marks_o,
    output carry_t                         rd_carry_o,
    input  logic                           wr_en_i,
    input  logic [$clog2(LINES)-1:0]       wr_line_i,
    input  logic [$clog2(LINE_CHUNKS)-1:0] wr_chunk_i,
    input  logic [CHUNK_BYTES-1:0]         wr_marks_i,
    input  carry_t                         wr_carry_i,
    input  logic                           clr_en_i,
    input  logic [$clog2(LINES)-1:0]       clr_line_i
);

    localparam int LINE_W  = $clog2(LINES);
    localparam int CHUNK_W = $clog2(LINE_CHUNKS);
    localparam int SLOT_W  = LINE_W + CHUNK_W;
    localparam int SLOTS   = 1 << SLOT_W;

    logic [SLOTS-1:0]       valid_d, valid_q;
    logic [CHUNK_BYTES-1:0] marks_d [SLOTS];
    logic [CHUNK_BYTES-1:0] marks_q [SLOTS];
    carry_t                 ends_d  [SLOTS];
    carry_t                 ends_q  [SLOTS];
    logic [LINES-1:0]       line_any;

    assign rd_valid_o = valid_q[{rd_line_i, rd_chunk_i}];
    assign rd_marks_o = marks_q[{rd_line_i, rd_chunk_i}];
    assign rd_carry_o = ends_q[{rd_line_i, rd_chunk_i}];

    always_comb begin
        valid_d = valid_q;
        marks_d = marks_q;
        ends_d  = ends_q;
        if (wr_en_i) begin
            valid_d[{wr_line_i, wr_chunk_i}] = 1'b1;
            marks_d[{wr_line_i, wr_chunk_i}] = wr_marks_i;
            ends_d[{wr_line_i, wr_chunk_i}]  = wr_carry_i;
        end
        if (clr_en_i) begin
            for (int c = 0; c < LINE_CHUNKS; c++) begin
                valid_d[{clr_line_i, CHUNK_W'(c)}] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
            marks_q <= marks_d;
            ends_q  <= ends_d;
        end
    end

    // Per-line summary used to check invalidation.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign line_any[g] = |valid_q[g*LINE_CHUNKS +: LINE_CHUNKS];
    end

    assert_refill_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> !line_any[$past(clr_line_i)]);

endmodule

// File: rtl/boundary_predecode.sv
module boundary_predecode
    import bpd_pkg::*;
#(
    parameter int CHUNK_BYTES = 8,
    parameter int LINES       = 8,
    parameter int LINE_CHUNKS = 4,
    parameter int PRE_STAGES  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fetch_valid_i,
    output logic                           fetch_ready_o,
    input  logic [$clog2(LINES)-1:0]       fetch_line_i,
    input  logic [$clog2(LINE_CHUNKS)-1:0] fetch_chunk_i,
    input  logic                           fetch_restart_i,
    input  logic [8*CHUNK_BYTES-1:0]       fetch_bytes_i,
    input  logic                           refill_i,
    input  logic [$clog2(LINES)-1:0]       refill_line_i,
    output logic                           out_valid_o,
    output logic [8*CHUNK_BYTES-1:0]       out_bytes_o,
    output logic [CHUNK_BYTES-1:0]         out_marks_o
);

    localparam int LINE_W  = $clog2(LINES);
    localparam int CHUNK_W = $clog2(LINE_CHUNKS);
    localparam int DATA_W  = 8 * CHUNK_BYTES;
    localparam int CNT_W   = $clog2(PRE_STAGES + 1);

    typedef struct packed {
        logic                   busy;
        logic [CNT_W-1:0]       cnt;
        logic                   stale;
        logic [LINE_W-1:0]      line;
        logic [CHUNK_W-1:0]     chunk;
        logic [DATA_W-1:0]      bytes;
        carry_t                 pend_carry;
        carry_t                 carry;
        logic                   out_valid;
        logic [DATA_W-1:0]      out_bytes;
        logic [CHUNK_BYTES-1:0] out_marks;
    } st_t;

    st_t st_d, st_q;

    logic                   rd_valid;
    logic [CHUNK_BYTES-1:0] rd_marks;
    carry_t                 rd_carry;
    logic [CHUNK_BYTES-1:0] scan_marks;
    carry_t                 scan_carry;
    logic                   refill_hits_fetch;
    logic                   refill_hits_pend;
    logic                   hit;
    logic                   accept;
    logic                   finish;
    logic                   wr_en;

    bpd_mark_store #(
        .LINES       (LINES),
        .LINE_CHUNKS (LINE_CHUNKS),
        .CHUNK_BYTES (CHUNK_BYTES)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_line_i  (fetch_line_i),
        .rd_chunk_i (fetch_chunk_i),
        .rd_valid_o (rd_valid),
        .rd_marks_o (rd_marks),
        .rd_carry_o (rd_carry),
        .wr_en_i    (wr_en),
        .wr_line_i  (st_q.line),
        .wr_chunk_i (st_q.chunk),
        .wr_marks_i (scan_marks),
        .wr_carry_i (scan_carry),
        .clr_en_i   (refill_i),
        .clr_line_i (refill_line_i)
    );

    bpd_scanner #(
        .CHUNK_BYTES (CHUNK_BYTES)
    ) i_scan (
        .carry_i (st_q.pend_carry),
        .bytes_i (st_q.bytes),
        .marks_o (scan_marks),
        .carry_o (scan_carry)
    );

    assign refill_hits_fetch = refill_i && (refill_line_i == fetch_line_i);
    assign refill_hits_pend  = refill_i && (refill_line_i == st_q.line);
    assign hit               = rd_valid && !refill_hits_fetch;
    assign accept            = fetch_valid_i && !st_q.busy;
    assign finish            = st_q.busy && (st_q.cnt == '0);
    assign wr_en             = finish && !st_q.stale && !refill_hits_pend;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        if (accept) begin
            if (hit) begin
                st_d.out_valid = 1'b1;
                st_d.out_bytes = fetch_bytes_i;
                st_d.out_marks = rd_marks;
                st_d.carry     = rd_carry;
            end else begin
                st_d.busy       = 1'b1;
                st_d.cnt        = CNT_W'(PRE_STAGES - 1);
                st_d.stale      = 1'b0;
                st_d.line       = fetch_line_i;
                st_d.chunk      = fetch_chunk_i;
                st_d.bytes      = fetch_bytes_i;
                st_d.pend_carry = fetch_restart_i ? CARRY_START : st_q.carry;
            end
        end else if (st_q.busy) begin
            if (refill_hits_pend) begin
                st_d.stale = 1'b1;
            end
            if (finish) begin
                st_d.busy      = 1'b0;
                st_d.out_valid = 1'b1;
                st_d.out_bytes = st_q.bytes;
                st_d.out_marks = scan_marks;
                st_d.carry     = scan_carry;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_ready_o = !st_q.busy;
    assign out_valid_o   = st_q.out_valid;
    assign out_bytes_o   = st_q.out_bytes;
    assign out_marks_o   = st_q.out_marks;

    assert_hit_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && fetch_ready_o && hit) |=> (out_valid_o && fetch_ready_o));

    assert_miss_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && fetch_ready_o && !hit) |=> (!out_valid_o && !fetch_ready_o));

    assert_first_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.pend_carry.phase != PH_START) |-> !scan_marks[0]);

    assert_restart_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.pend_carry.phase == PH_START) |-> scan_marks[0]);

endmodule

// File: tb/test_boundary_predecode.sv
`timescale 1ns/1ps
module test_boundary_predecode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        fetch_ready;
    logic [2:0]  fetch_line = '0;
    logic [1:0]  fetch_chunk = '0;
    logic        fetch_restart = 1'b0;
    logic [63:0] fetch_bytes = '0;
    logic        refill = 1'b0;
    logic [2:0]  refill_line = '0;
    logic        out_valid;
    logic [63:0] out_bytes;
    logic [7:0]  out_marks;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    boundary_predecode i_boundary_predecode (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_valid_i   (fetch_valid),
        .fetch_ready_o   (fetch_ready),
        .fetch_line_i    (fetch_line),
        .fetch_chunk_i   (fetch_chunk),
        .fetch_restart_i (fetch_restart),
        .fetch_bytes_i   (fetch_bytes),
        .refill_i        (refill),
        .refill_line_i   (refill_line),
        .out_valid_o     (out_valid),
        .out_bytes_o     (out_bytes),
        .out_marks_o     (out_marks)
    );

    localparam logic [63:0] NOPS  = 64'h9090_9090_9090_9090;
    localparam logic [63:0] B_V2  = 64'h0504_9044_3322_11B8;
    localparam logic [63:0] B_V3  = 64'h0001_C381_C0AF_0F66;
    localparam logic [63:0] B_V4  = 64'hC304_0302_01E8_0000;
    localparam logic [63:0] B_V5  = 64'h0FF3_9090_9090_9090;
    localparam logic [63:0] B_V6  = 64'h9090_9090_9090_C110;
    localparam logic [63:0] B_V8  = 64'h9090_9090_9005_C083;

    // {line[3], chunk[2], restart, bytes[64], marks[8], hit}
    localparam int NV = 11;
    localparam logic [78:0] VEC [NV] = '{
        {3'd0, 2'd0, 1'b1, NOPS, 8'hFF, 1'b0},
        {3'd0, 2'd0, 1'b1, NOPS, 8'hFF, 1'b1},
        {3'd1, 2'd0, 1'b1, B_V2, 8'h61, 1'b0},
        {3'd1, 2'd1, 1'b0, B_V3, 8'h11, 1'b0},
        {3'd1, 2'd2, 1'b0, B_V4, 8'h84, 1'b0},
        {3'd1, 2'd3, 1'b0, B_V5, 8'h7F, 1'b0},
        {3'd2, 2'd0, 1'b0, B_V6, 8'hFC, 1'b0},
        {3'd1, 2'd2, 1'b1, B_V4, 8'h84, 1'b1},
        {3'd2, 2'd1, 1'b0, B_V8, 8'hF9, 1'b0},
        {3'd1, 2'd3, 1'b0, B_V5, 8'h7F, 1'b1},
        {3'd3, 2'd0, 1'b0, B_V6, 8'hFC, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge with the block ready.
    task automatic do_fetch(input logic [2:0] line, input logic [1:0] chunk,
                            input logic rs, input logic [63:0] data,
                            input logic [7:0] exp_m, input int exp_lat,
                            input logic refill_same, input string tag);
        int lat;
        fetch_valid   = 1'b1;
        fetch_line    = line;
        fetch_chunk   = chunk;
        fetch_restart = rs;
        fetch_bytes   = data;
        if (refill_same) begin
            refill      = 1'b1;
            refill_line = line;
        end
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        refill      = 1'b0;
        lat = 1;
        if (exp_lat > 1)
            check(fetch_ready == 1'b0, {tag, " R5 ready low while scanning"},
                  64'(fetch_ready), 64'd0);
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " latency"}, 64'(lat), 64'(exp_lat));
        check(out_marks == exp_m, {tag, " marks"}, 64'(out_marks), 64'(exp_m));
        check(out_bytes == data, {tag, " R1 bytes pass through"}, out_bytes, data);
    endtask

    task automatic do_refill(input logic [2:0] line);
        refill      = 1'b1;
        refill_line = line;
        @(negedge clk);
        refill = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle after reset
        check(out_valid == 1'b0, "R9 out_valid after reset", 64'(out_valid), 64'd0);
        check(fetch_ready == 1'b1, "R9 ready after reset", 64'(fetch_ready), 64'd1);

        // Table walk: R2 R3 marks, R4 hits, R5 misses
        for (int i = 0; i < NV; i++) begin
            logic [78:0] v;
            v = VEC[i];
            do_fetch(v[78:76], v[75:74], v[73], v[72:9], v[8:1],
                     v[0] ? 1 : 4, 1'b0,
                     $sformatf("vec%0d %s R2 R3", i, v[0] ? "R4" : "R5"));
        end

        // R6: refill of line 1 forces a rescan from the current (start) state
        do_refill(3'd1);
        do_fetch(3'd1, 2'd2, 1'b0, B_V4, 8'h85, 4, 1'b0, "R6 refilled line rescanned");
        // R6: other lines keep their marks
        do_fetch(3'd0, 2'd0, 1'b1, NOPS, 8'hFF, 1, 1'b0, "R6 untouched line hits");
        // R6: refill in the same cycle as the fetch
        do_fetch(3'd0, 2'd0, 1'b1, NOPS, 8'hFF, 4, 1'b1, "R6 same-cycle refill");

        // R7: refill during a pending scan blocks the write-back
        fetch_valid   = 1'b1;
        fetch_line    = 3'd4;
        fetch_chunk   = 2'd0;
        fetch_restart = 1'b1;
        fetch_bytes   = NOPS;
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        check(fetch_ready == 1'b0, "R7 R5 busy during scan", 64'(fetch_ready), 64'd0);
        refill      = 1'b1;
        refill_line = 3'd4;
        @(negedge clk);
        refill = 1'b0;
        for (int w = 0; w < 20 && !out_valid; w++) @(negedge clk);
        check(out_valid == 1'b1, "R7 pending scan completes", 64'(out_valid), 64'd1);
        @(negedge clk);
        do_fetch(3'd4, 2'd0, 1'b1, NOPS, 8'hFF, 4, 1'b0, "R7 slot not written");
        do_fetch(3'd4, 2'd0, 1'b1, NOPS, 8'hFF, 1, 1'b0, "R7 later write kept");

        // R8: restart overrides a carried mid-instruction state
        do_fetch(3'd5, 2'd0, 1'b1, B_V5, 8'h7F, 4, 1'b0, "R8 setup");
        do_fetch(3'd5, 2'd1, 1'b1, B_V6, 8'hFD, 4, 1'b0, "R8 restart scan");
        // R8: a hit loads the stored end state, used by the next miss
        do_fetch(3'd5, 2'd0, 1'b0, B_V5, 8'h7F, 1, 1'b0, "R8 hit loads carry");
        do_fetch(3'd6, 2'd0, 1'b0, B_V6, 8'hFC, 4, 1'b0, "R8 R3 carry from store");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule